// File: doc/BRIEF.md
# Selectable Deselect Read Output Stage

This block is the read-data output stage of a pipelined synchronous static RAM. Commands (read, write, deselect) are captured by an input register on every rising clock edge. A small registered read port stands in for the storage array and feeds the output stage. Read data is registered and reaches the data bus one edge after the command was captured, so the data follows the second rising edge that comes after the command.

The output is modelled as a data vector plus a per-bit drive-enable vector rather than as true three-state pins. A static mode input picks how long the drivers stay on after a deselect:

- **Single-cycle mode** turns them off at the first edge after the deselect is captured.
- **Dual-cycle mode** keeps the last read word on the bus for one more cycle and turns it off an edge later.

An active-low output enable gates the drivers asynchronously. A sleep input forces the drivers off and makes commands be ignored, while stored words are kept.

Top module: `sram_rdout_stage`

## Requirements
- R1: While reset is asserted, and after reset until the first read result is due, every bit of `dq_oe` is 0.
- R2: A read captured at edge c, with `oe_n` low and `sleep` low, makes `dq_out` equal to the stored word and `dq_oe` all ones from edge c+1. Back-to-back reads give one word per cycle.
- R3: A write captured at edge c updates byte b (bits 8b+7..8b) only when `wbe[b]` is 1 and leaves the other bytes unchanged. A read captured at c+1 or later returns the new word.
- R4: With `scd_mode`=1 (single-cycle), any command other than a read captured at edge c makes `dq_oe` all zeros from edge c+1.
- R5: With `scd_mode`=0 (dual-cycle), a deselect captured at edge c directly after a read keeps the last read word and its enable for one extra cycle. The drive ends from c+2 unless a read captured at c+1 supplies the next word at c+2.
- R6: A write captured at edge c makes `dq_oe` all zeros from edge c+1 in both modes, with no extra hold cycle.
- R7: `oe_n` high forces `dq_oe` to zero at once, without waiting for a clock edge. `oe_n` low enables the drivers only while a read result is pending.
- R8: A read issued with `oe_n` high still loads its word. Lowering `oe_n` while that result is pending drives the word.
- R9: `sleep` high forces `dq_oe` to zero at once. Commands sampled while `sleep` is high act as deselects, so writes are dropped. Stored words are kept across sleep.
- R10: The `cmd` encoding is 2'b00 deselect, 2'b01 read and 2'b10 write. The value 2'b11 behaves as a deselect.
- R11: All bits of `dq_oe` are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| scd_mode | input | 1 | Deselect timing: 1 single-cycle, 0 dual-cycle; static |
| sleep | input | 1 | Standby, active high; drivers off, commands ignored |
| oe_n | input | 1 | Asynchronous output enable, active low |
| cmd | input | 2 | Command: 00 deselect, 01 read, 10 write, 11 deselect |
| addr | input | ADDR_W | Word address, captured with the command |
| wdata | input | DATA_W | Write word, captured with the command |
| wbe | input | DATA_W/BYTE_W | Per-byte write enable, active high |
| dq_out | output | DATA_W | Read data bus |
| dq_oe | output | DATA_W | Per-bit drive enable for `dq_out` |

## Verification
Several properties are checked on every cycle:

- The asynchronous gating by `oe_n` and `sleep`.
- The uniform enable vector.
- Turn-on two edges after a captured read.
- Turn-off after a captured write.
- The single-cycle release.
- The dual-cycle extra hold with stable data, and its release after two idle captures.

Only the bench scenarios can show that the returned words are the right ones. That covers byte-masked merges, retention across sleep with a dropped write, a dummy read revealed later by `oe_n`, and reset behaviour followed by a mode change.

// File: rtl/rdo_pkg.sv
// Package: shared command encoding for the read output stage.
// Assumes a two-bit command field driven by the surrounding control logic.
package rdo_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_RD    = 2'b01,
        OP_WR    = 2'b10,
        OP_SPARE = 2'b11
    } op_e;

endpackage

// File: rtl/rdo_capture.sv
// Module: input register stage. Captures the command, address, write word
// and byte mask on each rising edge. Sleep or the spare code turn the
// captured command into an idle one.
// Assumes: synchronous active-low reset; inputs meet setup to clk.
module rdo_capture
    import rdo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sleep,
    input  logic [1:0]                 cmd,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [DATA_W/BYTE_W-1:0]   wbe,
    output op_e                        op_q,
    output logic [ADDR_W-1:0]          addr_q,
    output logic [DATA_W-1:0]          wdata_q,
    output logic [DATA_W/BYTE_W-1:0]   wbe_q
);
    localparam int NBYTES = DATA_W / BYTE_W;

    op_e op_d;

    // Decode the raw command; sleep and the spare code become idle.
    always_comb begin
        if (sleep) begin
            op_d = OP_IDLE;
        end else begin
            case (cmd)
                2'b01:   op_d = OP_RD;
                2'b10:   op_d = OP_WR;
                default: op_d = OP_IDLE;
            endcase
        end
    end

    // Register the decoded command and its operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            wbe_q   <= {NBYTES{1'b0}};
        end else begin
            op_q    <= op_d;
            addr_q  <= addr;
            wdata_q <= wdata;
            wbe_q   <= wbe;
        end
    end

endmodule

// File: rtl/rdo_store.sv
// Module: storage model with one byte-masked write port and a registered
// read port. One lane per byte, so byte writes never touch neighbours.
// Assumes: read and write never target the same cycle (single command).
module rdo_store #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [DATA_W/BYTE_W-1:0]   wbe,
    output logic [DATA_W-1:0]          rd_q
);
    localparam int NBYTES = DATA_W / BYTE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] cells [DEPTH];
        logic [BYTE_W-1:0] lane_q;

        // Write this byte lane when its mask bit is set.
        always_ff @(posedge clk) begin
            if (wr_en && wbe[b]) begin
                cells[addr] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end

        // Registered read of this byte lane.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (rd_en) begin
                lane_q <= cells[addr];
            end
        end

        assign rd_q[b*BYTE_W +: BYTE_W] = lane_q;
    end

endmodule

// File: rtl/rdo_window.sv
// Module: drive window tracker. Marks when a read result is pending on the
// bus and applies the extra hold cycle of dual-cycle deselect mode.
// Assumes: op_i comes from the input register; scd_mode is static.
module rdo_window
    import rdo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scd_mode,
    input  op_e  op_i,
    output logic valid
);
    logic hold_r;
    logic extend;

    // A single extra cycle after a read, only in dual mode and only on idle.
    assign extend = !scd_mode && (op_i == OP_IDLE) && valid && !hold_r;

    // Update the pending flag and the hold-used marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            hold_r <= 1'b0;
        end else begin
            valid  <= (op_i == OP_RD) || extend;
            hold_r <= extend;
        end
    end

endmodule

// File: rtl/rdo_drive.sv
// Module: output gate. Combines the pending flag with the asynchronous
// output enable and sleep, and fans the result out per byte lane.
// Assumes: oe_n and sleep may change at any time.
module rdo_drive #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              valid,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] dq_oe
);
    localparam int NBYTES = DATA_W / BYTE_W;

    logic lane_on;

    // Drivers are on only with a pending result, enable low and no sleep.
    assign lane_on = valid && !oe_n && !sleep;
    assign dq_out  = data;

    for (genvar b = 0; b < NBYTES; b++) begin : g_en
        assign dq_oe[b*BYTE_W +: BYTE_W] = {BYTE_W{lane_on}};
    end

endmodule

// File: rtl/sram_rdout_stage.sv
// Module: top of the read output stage. Input register, storage model,
// drive window tracker and output gate in series. Read data follows the
// capture edge by one edge; deselect release depends on scd_mode.
// Assumes: scd_mode is static between resets; DATA_W is a multiple of BYTE_W.
module sram_rdout_stage
    import rdo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scd_mode,
    input  logic                       sleep,
    input  logic                       oe_n,
    input  logic [1:0]                 cmd,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [DATA_W/BYTE_W-1:0]   wbe,
    output logic [DATA_W-1:0]          dq_out,
    output logic [DATA_W-1:0]          dq_oe
);
    localparam int NBYTES = DATA_W / BYTE_W;

    op_e                 op_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [NBYTES-1:0]   wbe_q;
    logic [DATA_W-1:0]   rd_word;
    logic                pend;

    rdo_capture #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .cmd(cmd), .addr(addr),
        .wdata(wdata), .wbe(wbe), .op_q(op_q), .addr_q(addr_q),
        .wdata_q(wdata_q), .wbe_q(wbe_q)
    );

    rdo_store #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .rd_en(op_q == OP_RD), .wr_en(op_q == OP_WR),
        .addr(addr_q), .wdata(wdata_q), .wbe(wbe_q), .rd_q(rd_word)
    );

    rdo_window u_win (
        .clk(clk), .rst_n(rst_n), .scd_mode(scd_mode), .op_i(op_q), .valid(pend)
    );

    rdo_drive #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_drv (
        .valid(pend), .oe_n(oe_n), .sleep(sleep), .data(rd_word),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

endmodule

// File: rtl/rdo_checker.sv
// Module: property checker for sram_rdout_stage, attached by bind.
// Observes only the top-level ports.
module rdo_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scd_mode,
    input logic              sleep,
    input logic              oe_n,
    input logic [1:0]        cmd,
    input logic [DATA_W-1:0] dq_out,
    input logic [DATA_W-1:0] dq_oe
);
    logic take_rd, take_wr, take_idle;

    assign take_rd   = (cmd == 2'b01) && !sleep;
    assign take_wr   = (cmd == 2'b10) && !sleep;
    assign take_idle = !take_rd && !take_wr;

    // R11
    a_r11_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe == '0) || (dq_oe == '1));

    // R7
    a_r7_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (dq_oe == '0));

    // R9
    a_r9_sleep_gate: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (dq_oe == '0));

    // R2
    a_r2_read_on: assert property (@(posedge clk) disable iff (!rst_n)
        take_rd |=> ##1 (oe_n || sleep || (dq_oe == '1)));

    // R6
    a_r6_write_off: assert property (@(posedge clk) disable iff (!rst_n)
        take_wr |=> ##1 (dq_oe == '0));

    // R4
    a_r4_single_off: assert property (@(posedge clk) disable iff (!rst_n)
        (scd_mode && !take_rd) |=> ##1 (dq_oe == '0));

    // R5
    a_r5_dual_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!scd_mode && take_rd) ##1 take_idle |=> ##1 (oe_n || sleep || (dq_oe == '1)));

    // R5
    a_r5_dual_data: assert property (@(posedge clk) disable iff (!rst_n)
        (!scd_mode && take_rd) ##1 take_idle |=> ##1 $stable(dq_out));

    // R5
    a_r5_dual_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!scd_mode && take_idle) ##1 take_idle |=> ##1 (dq_oe == '0));

endmodule

bind sram_rdout_stage rdo_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scd_mode(scd_mode), .sleep(sleep), .oe_n(oe_n),
    .cmd(cmd), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/sim_sram_rdout_stage.sv
`timescale 1ns/1ps
module sim_sram_rdout_stage;
    localparam int DW = 32;
    localparam int AW = 4;

    typedef struct {
        logic          en;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    typedef struct {
        logic [1:0]    op;
        int            a;
        logic [DW-1:0] wd;
        logic [3:0]    be;
    } cmd_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scd_mode = 1'b1;
    logic          sleep = 1'b0;
    logic          oe_n = 1'b0;
    logic [1:0]    cmd = 2'b00;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [3:0]    wbe = '0;
    logic [DW-1:0] dq_out;
    logic [DW-1:0] dq_oe;

    int   n_vec = 0;
    int   n_bad = 0;
    exp_t q[$];

    logic [DW-1:0] ref_mem [16];
    logic          m_valid = 1'b0;
    logic          m_hold  = 1'b0;
    logic [DW-1:0] m_data  = '0;
    cmd_t          h_old, h_new;

    always #2.5 clk = ~clk;

    sram_rdout_stage #(.DATA_W(DW), .BYTE_W(8), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .scd_mode(scd_mode), .sleep(sleep), .oe_n(oe_n),
        .cmd(cmd), .addr(addr), .wdata(wdata), .wbe(wbe), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // Reference: effect of one captured command on the expected bus state.
    task automatic model_apply(input cmd_t c);
        if (c.op == 2'b01) begin
            m_data = ref_mem[c.a]; m_valid = 1'b1; m_hold = 1'b0;
        end else if (c.op == 2'b10) begin
            for (int b = 0; b < 4; b++)
                if (c.be[b]) ref_mem[c.a][b*8 +: 8] = c.wd[b*8 +: 8];
            m_valid = 1'b0; m_hold = 1'b0;
        end else if (!scd_mode && m_valid && !m_hold) begin
            m_hold = 1'b1;
        end else begin
            m_valid = 1'b0; m_hold = 1'b0;
        end
    endtask

    // Driver: apply one command cycle and queue the expected bus state.
    task automatic step(input logic [1:0] op, input int a, input logic [DW-1:0] wd,
                        input logic [3:0] be, input logic oen, input logic slp,
                        input string tag);
        exp_t e;
        @(posedge clk); #1;
        model_apply(h_old);
        h_old = h_new;
        h_new.op = (slp || op == 2'b11) ? 2'b00 : op;
        h_new.a = a; h_new.wd = wd; h_new.be = be;
        cmd = op; addr = AW'(a); wdata = wd; wbe = be; oe_n = oen; sleep = slp;
        e.en = m_valid && !oen && !slp; e.data = m_data; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic rd(input int a, input string tag);
        step(2'b01, a, '0, 4'h0, 1'b0, 1'b0, tag);
    endtask
    task automatic wr(input int a, input logic [DW-1:0] d, input logic [3:0] be, input string tag);
        step(2'b10, a, d, be, 1'b0, 1'b0, tag);
    endtask
    task automatic idle(input string tag);
        step(2'b00, 0, '0, 4'h0, 1'b0, 1'b0, tag);
    endtask

    // Reset with a chosen mode; expects drivers off throughout (R1).
    task automatic do_reset(input logic mode);
        exp_t e;
        rst_n = 1'b0; scd_mode = mode; cmd = 2'b00; oe_n = 1'b0; sleep = 1'b0;
        repeat (3) begin
            @(posedge clk); #1;
            e.en = 1'b0; e.data = '0; e.tag = "R1 in reset";
            q.push_back(e);
        end
        rst_n = 1'b1;
        m_valid = 1'b0; m_hold = 1'b0; m_data = '0;
        h_old = '{2'b00, 0, '0, 4'h0};
        h_new = '{2'b00, 0, '0, 4'h0};
    endtask

    // Monitor: compare the bus away from the active edge (also checks R11).
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (dq_oe !== {DW{e.en}}) begin
                n_bad++;
                $display("FAIL %s: dq_oe=%h expected %h", e.tag, dq_oe, {DW{e.en}});
            end else if (e.en && dq_out !== e.data) begin
                n_bad++;
                $display("FAIL %s: dq_out=%h expected %h", e.tag, dq_out, e.data);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: cycles=200000 expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // Single-cycle mode
        do_reset(1'b1);
        idle("R1 after reset");
        wr(1, 32'hA1B2C3D4, 4'hF, "R3 write a1");
        wr(2, 32'h11223344, 4'hF, "R3 write a2");
        wr(3, 32'h55667788, 4'hF, "R1 no read yet");
        wr(3, 32'hFFFFFFFF, 4'b0101, "R3 masked write");
        rd(1, "R6 write off");
        rd(2, "R6 write off");
        rd(3, "R2 read a1");
        idle("R2 read a2");
        idle("R3 merged word a3");
        idle("R4 single off");
        rd(1, "R4 still off");
        wr(4, 32'hCAFEF00D, 4'hF, "R4 idle");
        idle("R2 read a1 before write");
        idle("R6 write single off");
        rd(2, "R6 off");
        step(2'b11, 0, '0, 4'h0, 1'b0, 1'b0, "R10 spare op");
        idle("R10 read a2");
        idle("R10 spare acts as deselect");
        // Dummy read then reveal
        step(2'b01, 1, '0, 4'h0, 1'b1, 1'b0, "R8 dummy read");
        step(2'b00, 0, '0, 4'h0, 1'b1, 1'b0, "R7 oe high");
        step(2'b00, 0, '0, 4'h0, 1'b0, 1'b0, "R8 reveal dummy data");
        step(2'b00, 0, '0, 4'h0, 1'b0, 1'b0, "R7 no pending read");
        rd(2, "R7 oe low idle");
        idle("R7");
        step(2'b00, 0, '0, 4'h0, 1'b1, 1'b0, "R7 oe high over pending read");
        idle("R7 off");
        // Sleep behaviour
        wr(5, 32'h12345678, 4'hF, "R9 setup");
        idle("R9");
        rd(5, "R9");
        idle("R9");
        step(2'b10, 5, 32'hDEADBEEF, 4'hF, 1'b0, 1'b1, "R9 sleep gates pending read");
        step(2'b00, 0, '0, 4'h0, 1'b0, 1'b1, "R9 sleeping");
        idle("R9 woken");
        rd(5, "R9");
        idle("R9");
        idle("R9 word retained, sleep write dropped");
        idle("R4");
        // Dual-cycle mode
        do_reset(1'b0);
        idle("R1 after reset dual");
        rd(1, "R1");
        idle("R1");
        idle("R5 read a1 dual");
        idle("R5 extra hold");
        idle("R5 released");
        rd(1, "R5");
        idle("R5");
        rd(2, "R5 a1");
        idle("R5 a1 held");
        idle("R5 a2 takes over");
        idle("R5 a2 held");
        rd(3, "R5 released");
        rd(1, "R5");
        rd(2, "R2 back to back a3");
        wr(6, 32'h0F0F0F0F, 4'hF, "R2 back to back a1");
        idle("R2 back to back a2");
        idle("R6 write no hold dual");
        idle("R6 off");
        idle("R6 off");
        repeat (3) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule